// File: doc/BRIEF.md
# Receive ring buffer writer

This block takes received Ethernet frames, one byte per cycle, and lays them down in a circular receive buffer in memory. Each frame is stored behind a single 32-bit header word. The header carries the frame's receive status in its low half and its byte count in its high half. Payload bytes follow the header, packed little-endian into 32-bit words. The start of the next frame is rounded up to a 4-byte boundary, so every header is word aligned.

Software drains the ring through a small register port. It writes how far it has consumed into a read-pointer register, using the consumed offset minus 16. The block compares that position with its own committed write pointer. From this it reports whether any unread frame remains. It also refuses any frame that would run into bytes software has not yet consumed. Received-good, received-with-error and dropped-for-lack-of-space events latch into a sticky interrupt status register that software clears by writing ones.

The ring size is selected from a base size by a two-bit index, and every offset wraps modulo the selected size. Address matching and the bus protocol used to reach memory belong to neighbouring blocks. The input stream must not deliver a one-byte frame straight after the end of another frame, because the header of the earlier frame uses the memory port in that cycle.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the buffer-empty flag is 1, the interrupt status is 0, the write pointer (register address 3) is 0, and the read-pointer register (address 0) reads 0xFFF0.
- R2: The size index selects a ring of 8 KiB (0), 16 KiB (1) or 32 KiB (2); every memory write address is word aligned and lies below the selected size, and offsets wrap modulo that size.
- R3: Frame byte i is stored at ring offset (start + 4 + i) modulo the ring size, four bytes per 32-bit word with byte i mod 4 in lane i mod 4; a final partial word enables only its filled lanes.
- R4: The word at the frame's start offset holds the received byte count (FCS included) in bits 31:16 and the status in bits 15:0, and it is written after the frame's last payload word.
- R5: Status encoding: bit 0 = no error flag, bit 1 = alignment error, bit 2 = CRC error, bit 3 = too long, bit 4 = runt, bit 5 = bad symbol (error input bits 0..4 in that order), bit 13 = broadcast, bit 14 = own-address match, bit 15 = multicast (class input bits 0..2 in that order); all other bits 0.
- R6: After a stored frame of length L starting at S, the write pointer becomes (S + L + 4 rounded up to a multiple of 4) modulo the ring size.
- R7: Writing V to register address 0 stores V (read back unchanged) and sets the consumed offset to (V + 16) modulo the ring size.
- R8: Bit 0 of register address 2 is 1 exactly when the consumed offset equals the write pointer; it stays 1 until a frame's header is in the ring.
- R9: Interrupt status (register address 1): bit 0 is set by a stored frame without error flags, bit 1 by a stored frame with any error flag, bit 4 by a dropped frame; bits stay set until cleared.
- R10: A write to register address 1 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R11: A frame whose footprint (L + 4 rounded up to 4) added to the unread byte count would reach the ring size is dropped: no header is written, the write pointer does not move, bit 4 is set, bits 0 and 1 are not, and earlier frames stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size_idx | input | 2 | Ring size index (0, 1, 2); static outside reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| in_err | input | 5 | Error flags, sampled with the last byte |
| in_cast | input | 3 | Address class flags, sampled with the last byte |
| mem_we | output | 1 | Ring memory word write strobe |
| mem_addr | output | 15 | Byte offset of the word in the ring |
| mem_wdata | output | 32 | Word to write |
| mem_be | output | 4 | Byte lane enables |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |

## Verification
The bench aims at the rounding of odd lengths to the next word. An off-by-one there would shift every later header and show up as a wrong write pointer. It also fills an 8 KiB ring with unconsumed frames so that one frame would close the gap exactly. A design that let that frame in would make a full ring look empty, and one that wrote its header would destroy the oldest unread frame. A frame that crosses the end of the ring must land its tail at offset 0, not past the end. The same traffic on a 16 KiB ring must not wrap at 8 KiB. The bench also checks that a zero data bit leaves a status bit alone, which catches a plain overwrite in place of write-one-to-clear.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef logic [15:0] ptr_t;

    // register addresses
    localparam logic [1:0] REG_RDPTR = 2'd0;
    localparam logic [1:0] REG_IRQ   = 2'd1;
    localparam logic [1:0] REG_STAT  = 2'd2;
    localparam logic [1:0] REG_WRPTR = 2'd3;

    // interrupt status bit positions
    localparam int IRQ_OK_BIT  = 0;
    localparam int IRQ_ERR_BIT = 1;
    localparam int IRQ_OVF_BIT = 4;

    // software pointer bias and its reset image (consumed offset 0)
    localparam ptr_t RDPTR_BIAS = 16'd16;
    localparam ptr_t RDPTR_RST  = 16'hFFF0;

    localparam int HDR_BYTES = 4;

endpackage

// File: rtl/rxr_space.sv
module rxr_space
    import rxr_pkg::*;
#(
    parameter int BASE_BYTES = 8192,
    parameter int MAX_SHIFT  = 2
) (
    input  logic [1:0]  size_idx,
    input  ptr_t        capr,
    input  ptr_t        start,
    input  ptr_t        wr,
    output logic [16:0] size,
    output ptr_t        mask,
    output ptr_t        used,
    output logic        empty
);
    logic [1:0] shift;
    ptr_t       rd_off;

    always_comb begin
        shift  = (32'(size_idx) > MAX_SHIFT) ? 2'(MAX_SHIFT) : size_idx;
        size   = 17'(BASE_BYTES) << shift;
        mask   = ptr_t'(size - 17'd1);
        rd_off = (capr + RDPTR_BIAS) & mask;
        used   = (start - rd_off) & mask;
        empty  = (rd_off == wr);
    end

endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        ev_ok,
    input  logic        ev_err,
    input  logic        ev_ovf,
    input  logic        empty,
    input  ptr_t        wr_ptr,
    output ptr_t        capr,
    output logic [15:0] irq
);
    typedef struct packed {
        ptr_t        capr;
        logic [15:0] irq;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_we && reg_addr == REG_RDPTR) d.capr = reg_wdata;
        if (reg_we && reg_addr == REG_IRQ)   d.irq  = q.irq & ~reg_wdata;
        if (ev_ok)  d.irq[IRQ_OK_BIT]  = 1'b1;
        if (ev_err) d.irq[IRQ_ERR_BIT] = 1'b1;
        if (ev_ovf) d.irq[IRQ_OVF_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.capr <= RDPTR_RST;
            q.irq  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_RDPTR: reg_rdata = q.capr;
            REG_IRQ:   reg_rdata = q.irq;
            REG_STAT:  reg_rdata = {15'b0, empty};
            default:   reg_rdata = wr_ptr;
        endcase
    end

    assign capr = q.capr;
    assign irq  = q.irq;

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int BASE_RING_BYTES = 8192,
    parameter int MAX_SIZE_SHIFT  = 2,
    localparam int AW = $clog2(BASE_RING_BYTES) + MAX_SIZE_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_size_idx,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic [4:0]    in_err,
    input  logic [2:0]    in_cast,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata
);
    typedef struct packed {
        ptr_t          start;     // offset where the current frame begins
        ptr_t          wr;        // committed write pointer
        logic [15:0]   cnt;       // bytes received in current frame
        logic [23:0]   acc;       // partial word
        logic          drop;      // current frame refused
        logic          hdr_pend;
        logic [31:0]   hdr_word;
        logic [AW-1:0] hdr_addr;
        ptr_t          hdr_next;
        logic          mem_we;
        logic [AW-1:0] mem_addr;
        logic [31:0]   mem_wdata;
        logic [3:0]    mem_be;
        logic          ev_ok;
        logic          ev_err;
        logic          ev_ovf;
    } wst_t;

    wst_t q, d;

    logic [16:0] ring_size;
    ptr_t        ring_mask;
    ptr_t        ring_used;
    logic        ring_empty;
    ptr_t        capr;
    ptr_t        wr_ptr;
    logic [15:0] irq;

    assign wr_ptr = q.wr;

    rxr_space #(
        .BASE_BYTES (BASE_RING_BYTES),
        .MAX_SHIFT  (MAX_SIZE_SHIFT)
    ) space_i (
        .size_idx (cfg_size_idx),
        .capr     (capr),
        .start    (q.start),
        .wr       (q.wr),
        .size     (ring_size),
        .mask     (ring_mask),
        .used     (ring_used),
        .empty    (ring_empty)
    );

    rxr_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_ok     (q.ev_ok),
        .ev_err    (q.ev_err),
        .ev_ovf    (q.ev_ovf),
        .empty     (ring_empty),
        .wr_ptr    (wr_ptr),
        .capr      (capr),
        .irq       (irq)
    );

    logic [1:0]  lane;
    logic [31:0] word;
    logic [4:0]  be_wide;
    logic        word_done;
    logic [15:0] woff;
    logic [17:0] need;
    logic        fits;
    logic        drop_now;
    logic [15:0] flen;
    logic [16:0] footprint;
    ptr_t        nxt_start;
    ptr_t        data_off;
    logic [15:0] status;

    always_comb begin
        d        = q;
        d.mem_we = 1'b0;
        d.mem_be = 4'b0;
        d.ev_ok  = 1'b0;
        d.ev_err = 1'b0;
        d.ev_ovf = 1'b0;

        lane      = q.cnt[1:0];
        word      = {8'h00, q.acc};
        word[{lane, 3'b000} +: 8] = in_data;
        be_wide   = (5'd2 << lane) - 5'd1;
        word_done = (lane == 2'd3) || in_last;
        woff      = {q.cnt[15:2], 2'b00};
        need      = 18'(ring_used) + 18'(woff) + 18'(2 * HDR_BYTES);
        fits      = need < 18'(ring_size);
        drop_now  = q.drop || (word_done && !fits);
        flen      = q.cnt + 16'd1;
        footprint = (17'(flen) + 17'(HDR_BYTES) + 17'd3) & ~17'd3;
        nxt_start = ptr_t'(17'(q.start) + footprint) & ring_mask;
        data_off  = (q.start + ptr_t'(HDR_BYTES) + woff) & ring_mask;
        status    = {in_cast[2], in_cast[1], in_cast[0], 7'b0, in_err, ~|in_err};

        // header of the previous frame goes out first
        if (q.hdr_pend) begin
            d.mem_we    = 1'b1;
            d.mem_addr  = q.hdr_addr;
            d.mem_wdata = q.hdr_word;
            d.mem_be    = 4'hF;
            d.wr        = q.hdr_next;
            d.hdr_pend  = 1'b0;
        end

        if (in_valid) begin
            d.acc = (lane == 2'd3) ? 24'h0 : word[23:0];
            d.cnt = flen;
            if (word_done && !drop_now) begin
                d.mem_we    = 1'b1;
                d.mem_addr  = data_off[AW-1:0];
                d.mem_wdata = word;
                d.mem_be    = be_wide[3:0];
            end
            d.drop = drop_now;
            if (in_last) begin
                if (drop_now) begin
                    d.ev_ovf = 1'b1;
                end else begin
                    d.hdr_pend = 1'b1;
                    d.hdr_addr = q.start[AW-1:0];
                    d.hdr_word = {flen, status};
                    d.hdr_next = nxt_start;
                    d.start    = nxt_start;
                    d.ev_ok    = ~|in_err;
                    d.ev_err   = |in_err;
                end
                d.cnt  = '0;
                d.acc  = '0;
                d.drop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_we    = q.mem_we;
    assign mem_addr  = q.mem_addr;
    assign mem_wdata = q.mem_wdata;
    assign mem_be    = q.mem_be;

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic [16:0]   size,
    input logic [15:0]   wr,
    input logic          ev_ok,
    input logic          ev_ovf,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic [15:0]   reg_wdata,
    input logic [15:0]   irq
);
    // R2: writes stay word aligned inside the selected ring
    assert_addr_in_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (17'(mem_addr) < size) && (mem_addr[1:0] == 2'b00));

    // R3: lane enables fill from lane 0 upward
    assert_lanes_packed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

    // R6: write pointer is word aligned and within the ring
    assert_wr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr[1:0] == 2'b00) && (17'(wr) < size));

    // R11: a dropped frame leaves the write pointer where it was
    assert_drop_holds_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> $stable(wr));

    // R11: a dropped frame raises the overflow bit
    assert_drop_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> irq[4]);

    // R10: writing one clears the good-frame bit when no new event arrives
    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1 && reg_wdata[0] && !ev_ok) |=> !irq[0]);

    // R9: the good-frame bit stays until software clears it
    assert_ok_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && !(reg_we && reg_addr == 2'd1 && reg_wdata[0])) |=> irq[0]);

endmodule

bind rxr_ring_writer rxr_checker #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .size      (ring_size),
    .wr        (wr_ptr),
    .ev_ok     (q.ev_ok),
    .ev_ovf    (q.ev_ovf),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq)
);

// File: tb/rxr_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rxr_ring_writer_tb_top;

    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cfg_size_idx;
    logic          in_valid;
    logic [7:0]    in_data;
    logic          in_last;
    logic [4:0]    in_err;
    logic [2:0]    in_cast;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_be;
    logic          reg_we;
    logic [1:0]    reg_addr;
    logic [15:0]   reg_wdata;
    logic [15:0]   reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] ring [0:32767];

    always #2.5 clk = ~clk;

    rxr_ring_writer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_size_idx (cfg_size_idx),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_last      (in_last),
        .in_err       (in_err),
        .in_cast      (in_cast),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_be       (mem_be),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata)
    );

    // memory model behind the write port
    always @(posedge clk) begin
        if (mem_we) begin
            for (int k = 0; k < 4; k++) begin
                if (mem_be[k]) ring[32'(mem_addr) + k] <= mem_wdata[8*k +: 8];
            end
        end
    end

    function automatic logic [7:0] pat(int f, int i);
        return 8'((f * 7 + i * 3 + 1) & 8'hFF);
    endfunction

    function automatic logic [31:0] word_at(int off);
        return {ring[off+3], ring[off+2], ring[off+1], ring[off]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [1:0] idx);
        rst_n        = 1'b0;
        cfg_size_idx = idx;
        in_valid     = 1'b0;
        in_data      = '0;
        in_last      = 1'b0;
        in_err       = '0;
        in_cast      = '0;
        reg_we       = 1'b0;
        reg_addr     = '0;
        reg_wdata    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_wr(logic [1:0] a, logic [15:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic send(int f, int len, logic [4:0] err, logic [2:0] cast);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat(f, i);
            in_last  = (i == len - 1);
            in_err   = err;
            in_cast  = cast;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset(2'd0);
        reg_rd(2'd2, v); check("R1 empty after reset", 32'(v), 32'h1);
        reg_rd(2'd1, v); check("R1 irq after reset", 32'(v), 32'h0);
        reg_rd(2'd3, v); check("R1 write pointer after reset", 32'(v), 32'h0);
        reg_rd(2'd0, v); check("R1 read pointer after reset", 32'(v), 32'hFFF0);
    endtask

    task automatic t_good_frame();
        logic [15:0] v;
        int bad;
        send(1, 64, 5'b0, 3'b010);
        check("R4 R5 header good frame", word_at(0), {16'd64, 16'h4001});
        bad = 0;
        for (int i = 0; i < 64; i++) if (ring[4 + i] !== pat(1, i)) bad++;
        check("R3 payload bytes", 32'(bad), 32'h0);
        reg_rd(2'd3, v); check("R6 write pointer after 64 bytes", 32'(v), 32'd68);
        reg_rd(2'd1, v); check("R9 ok bit", 32'(v), 32'h1);
        reg_rd(2'd2, v); check("R8 not empty", 32'(v), 32'h0);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        reg_wr(2'd1, 16'h0002);
        reg_rd(2'd1, v); check("R10 zero bit leaves ok set", 32'(v), 32'h1);
        reg_wr(2'd1, 16'h0001);
        reg_rd(2'd1, v); check("R10 one clears ok", 32'(v), 32'h0);
    endtask

    task automatic t_err_frames();
        logic [15:0] v;
        send(2, 61, 5'b00010, 3'b001);
        check("R5 crc broadcast header", word_at(68), {16'd61, 16'h2004});
        reg_rd(2'd3, v); check("R6 odd length rounds up", 32'(v), 32'd136);
        reg_rd(2'd1, v); check("R9 err bit", 32'(v), 32'h2);
        send(3, 10, 5'b01000, 3'b100);
        check("R5 runt multicast header", word_at(136), {16'd10, 16'h8010});
        check("R3 partial word lanes", 32'(ring[136 + 4 + 9]), 32'(pat(3, 9)));
        reg_rd(2'd3, v); check("R6 short frame pointer", 32'(v), 32'd152);
    endtask

    task automatic t_consume();
        logic [15:0] v;
        reg_wr(2'd0, 16'd136);
        reg_rd(2'd0, v); check("R7 read pointer readback", 32'(v), 32'd136);
        reg_rd(2'd2, v); check("R8 empty after consume", 32'(v), 32'h1);
    endtask

    task automatic t_overflow_and_wrap();
        logic [15:0] v;
        do_reset(2'd0);
        for (int f = 0; f < 7; f++) send(10 + f, 1020, 5'b0, 3'b010);
        reg_wr(2'd1, 16'hFFFF);
        send(17, 1020, 5'b0, 3'b010);
        reg_rd(2'd1, v); check("R11 overflow bit only", 32'(v), 32'h10);
        reg_rd(2'd3, v); check("R11 write pointer held", 32'(v), 32'd7168);
        check("R11 last stored header intact", word_at(6144), {16'd1020, 16'h4001});
        check("R11 first header intact", word_at(0), {16'd1020, 16'h4001});
        reg_rd(2'd2, v); check("R8 full ring not empty", 32'(v), 32'h0);
        reg_wr(2'd0, 16'd7152);
        reg_rd(2'd2, v); check("R8 empty after full consume", 32'(v), 32'h1);
        send(20, 1500, 5'b0, 3'b010);
        check("R4 header before wrap", word_at(7168), {16'd1500, 16'h4001});
        check("R2 R3 byte wraps to offset 0", 32'(ring[0]), 32'(pat(20, 1020)));
        check("R3 last wrapped byte", 32'(ring[479]), 32'(pat(20, 1499)));
        reg_rd(2'd3, v); check("R6 R2 pointer wraps", 32'(v), 32'd480);
    endtask

    task automatic t_size16();
        logic [15:0] v;
        do_reset(2'd1);
        for (int f = 0; f < 8; f++) send(30 + f, 1020, 5'b0, 3'b010);
        reg_rd(2'd1, v); check("R2 16K ring takes eighth frame", 32'(v), 32'h1);
        reg_rd(2'd3, v); check("R2 no wrap at 8K", 32'(v), 32'd8192);
        send(40, 100, 5'b0, 3'b010);
        check("R2 header above 8K", word_at(8192), {16'd100, 16'h4001});
        check("R2 payload above 8K", 32'(ring[8196]), 32'(pat(40, 0)));
        reg_rd(2'd3, v); check("R6 pointer above 8K", 32'(v), 32'd8296);
    endtask

    initial begin
        t_reset();
        t_good_frame();
        t_w1c();
        t_err_frames();
        t_consume();
        t_overflow_and_wrap();
        t_size16();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule